// File: doc/BRIEF.md
# Programmable Interval Timer

A down-counting interval timer that sits on a word-addressed register bus with 16-bit data words. Software loads a 32-bit period in two 16-bit halves, sets the interrupt enable and the reload mode, and then issues a start command. The counter steps down by one every clock cycle. When it reaches zero it sets a timeout flag, raises a level interrupt if that is enabled, and reloads the period. In one-shot mode it then stops. In continuous mode it keeps running and produces a periodic tick.

To read the live count, software writes to either snapshot word. That write copies the whole counter into both snapshot words in one cycle, so the two halves always belong to the same instant. Software then reads the two halves. Elapsed cycles since the last reload are the period minus the captured value. Any write to the status word clears the timeout flag, and clearing the flag removes the interrupt.

Register map, by word offset:
- 0: status. Bit 0 is the timeout flag. Bit 1 shows that the counter is running.
- 1: control. Bit 0 is the interrupt enable. Bit 1 selects continuous reload. Bit 2 is the start command. Bit 3 is the stop command.
- 2: period, low half.
- 3: period, high half.
- 4: snapshot, low half.
- 5: snapshot, high half.

Top module: `itimer`

## Requirements
- R1: After reset, every readable word reads zero, the counter is stopped and `irq_o` is low.
- R2: Offset 2 holds the low half and offset 3 the high half of the period, and both read back. A write to either half stops the counter and loads the count with the new full period. The counter stays stopped until the next start command.
- R3: Control at offset 1 stores bit 0 (interrupt enable) and bit 1 (continuous). Both read back. Bits 2 and 3 read as zero. Offsets 6 and 7 read as zero.
- R4: Writing control with bit 2 set starts the countdown on the next cycle. The first expiry comes period+1 cycles after the start write. With bit 1 clear, the expiry sets status bit 0, clears status bit 1 (running) and reloads the count.
- R5: With control bit 1 set, each expiry reloads the period and the counter keeps running. Expiries then repeat every period+1 cycles.
- R6: A write of any value to offset 0 clears the timeout flag. If an expiry falls on the same cycle, the flag stays set.
- R7: `irq_o` is high exactly when the timeout flag and the interrupt enable are both set.
- R8: Writing control with bit 3 set stops the counter, and the count holds its value. When bits 2 and 3 are written together, the stop wins.
- R9: A write of any value to offset 4 or 5 copies the count, as it stood before that edge, into both snapshot words. The low half reads at offset 4 and the high half at offset 5. The written data is ignored.
- R10: Read data is registered. It appears on `rdata_o` in the cycle after `rd_en_i` and holds while `rd_en_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 3 | Word offset |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Registered read data |
| irq_o | output | 1 | Level interrupt |

## Verification
The bench builds the timer with the default 16-bit data width, which gives a 32-bit count. It keeps periods small (2 to 100) so that one-shot, continuous and same-cycle clear-versus-expiry cases all fall within a few dozen cycles. The high half of the counter is reached by loading it directly through the period and snapshot words, not by waiting for it to count down.

// File: rtl/itimer_pkg.sv
package itimer_pkg;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned HALVES = 2;

  localparam logic [ADDR_W-1:0] A_STATUS  = 3'd0;
  localparam logic [ADDR_W-1:0] A_CTRL    = 3'd1;
  localparam logic [ADDR_W-1:0] A_PER_LO  = 3'd2;
  localparam logic [ADDR_W-1:0] A_SNAP_LO = 3'd4;

  localparam int unsigned CB_IRQ_EN = 0;
  localparam int unsigned CB_CONT   = 1;
  localparam int unsigned CB_START  = 2;
  localparam int unsigned CB_STOP   = 3;

  localparam int unsigned SB_TIMEOUT = 0;
  localparam int unsigned SB_RUN     = 1;
endpackage

// File: rtl/itimer_regs.sv
module itimer_regs
  import itimer_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  localparam int unsigned CNT_W = HALVES * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              run_i,
  input  logic              expire_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_en_o,
  output logic              cont_o,
  output logic              start_o,
  output logic              stop_o,
  output logic              load_o,
  output logic [CNT_W-1:0]  period_o,
  output logic [CNT_W-1:0]  period_nxt_o,
  output logic              timeout_o,
  output logic [CNT_W-1:0]  snap_o
);
  logic [HALVES-1:0][DATA_W-1:0] per_q, per_d, snap_q;
  logic [HALVES-1:0]             per_wr;
  logic                          wr_status, wr_ctrl, wr_snap;
  logic                          irq_en_q, cont_q, to_q;
  logic [DATA_W-1:0]             rd_val, rdata_q;

  assign wr_status = wr_en_i && (addr_i == A_STATUS);
  assign wr_ctrl   = wr_en_i && (addr_i == A_CTRL);
  assign wr_snap   = wr_en_i && (addr_i >= A_SNAP_LO) &&
                     (addr_i < A_SNAP_LO + ADDR_W'(HALVES));

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    assign per_wr[h] = wr_en_i && (addr_i == A_PER_LO + ADDR_W'(h));
    assign per_d[h]  = per_wr[h] ? wdata_i : per_q[h];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) per_q[h] <= '0;
      else         per_q[h] <= per_d[h];
    end

    // both halves captured on the same edge
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      snap_q[h] <= '0;
      else if (wr_snap) snap_q[h] <= count_i[h*DATA_W +: DATA_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_en_q <= 1'b0;
      cont_q   <= 1'b0;
    end else if (wr_ctrl) begin
      irq_en_q <= wdata_i[CB_IRQ_EN];
      cont_q   <= wdata_i[CB_CONT];
    end
  end

  // expiry beats a same-cycle clear so no event is lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        to_q <= 1'b0;
    else if (expire_i)  to_q <= 1'b1;
    else if (wr_status) to_q <= 1'b0;
  end

  always_comb begin
    rd_val = '0;
    case (addr_i)
      A_STATUS: begin
        rd_val[SB_TIMEOUT] = to_q;
        rd_val[SB_RUN]     = run_i;
      end
      A_CTRL: begin
        rd_val[CB_IRQ_EN] = irq_en_q;
        rd_val[CB_CONT]   = cont_q;
      end
      A_PER_LO:      rd_val = per_q[0];
      A_PER_LO + 1:  rd_val = per_q[1];
      A_SNAP_LO:     rd_val = snap_q[0];
      A_SNAP_LO + 1: rd_val = snap_q[1];
      default:       rd_val = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_q <= '0;
    else if (rd_en_i) rdata_q <= rd_val;
  end

  assign rdata_o      = rdata_q;
  assign irq_en_o     = irq_en_q;
  assign cont_o       = cont_q;
  assign start_o      = wr_ctrl && wdata_i[CB_START];
  assign stop_o       = wr_ctrl && wdata_i[CB_STOP];
  assign load_o       = |per_wr;
  assign period_o     = per_q;
  assign period_nxt_o = per_d;
  assign timeout_o    = to_q;
  assign snap_o       = snap_q;
endmodule

// File: rtl/itimer_count.sv
module itimer_count #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             load_i,
  input  logic             cont_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] period_nxt_i,
  output logic [CNT_W-1:0] count_o,
  output logic             run_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] count_q;
  logic             run_q, at_zero, expire;

  assign at_zero = (count_q == '0);
  assign expire  = run_q && at_zero && !stop_i && !load_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
      run_q   <= 1'b0;
    end else if (load_i) begin
      count_q <= period_nxt_i;
      run_q   <= 1'b0;
    end else if (stop_i) begin
      run_q   <= 1'b0;
    end else begin
      if (run_q) count_q <= at_zero ? period_i : count_q - CNT_W'(1);
      run_q <= start_i || (run_q && !(expire && !cont_i));
    end
  end

  assign count_o  = count_q;
  assign run_o    = run_q;
  assign expire_o = expire;
endmodule

// File: rtl/itimer.sv
module itimer
  import itimer_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  localparam int unsigned CNT_W = HALVES * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  logic [CNT_W-1:0] count_w, period_w, period_nxt_w, snap_w;
  logic run_w, expire_w, irq_en_w, cont_w, start_w, stop_w, load_w, to_w;

  itimer_regs #(.DATA_W(DATA_W)) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .addr_i       (addr_i),
    .wr_en_i      (wr_en_i),
    .rd_en_i      (rd_en_i),
    .wdata_i      (wdata_i),
    .count_i      (count_w),
    .run_i        (run_w),
    .expire_i     (expire_w),
    .rdata_o      (rdata_o),
    .irq_en_o     (irq_en_w),
    .cont_o       (cont_w),
    .start_o      (start_w),
    .stop_o       (stop_w),
    .load_o       (load_w),
    .period_o     (period_w),
    .period_nxt_o (period_nxt_w),
    .timeout_o    (to_w),
    .snap_o       (snap_w)
  );

  itimer_count #(.CNT_W(CNT_W)) u_count (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_w),
    .stop_i       (stop_w),
    .load_i       (load_w),
    .cont_i       (cont_w),
    .period_i     (period_w),
    .period_nxt_i (period_nxt_w),
    .count_o      (count_w),
    .run_o        (run_w),
    .expire_o     (expire_w)
  );

  assign irq_o = to_w && irq_en_w;
endmodule

// File: rtl/itimer_checker.sv
module itimer_checker
  import itimer_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  localparam int unsigned CNT_W = HALVES * DATA_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wr_en_i,
  input logic              rd_en_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              irq_o,
  input logic [CNT_W-1:0]  count_i,
  input logic [CNT_W-1:0]  period_i,
  input logic [CNT_W-1:0]  snap_i,
  input logic              run_i,
  input logic              timeout_i,
  input logic              irq_en_i,
  input logic              cont_i
);
  p_period_lo_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == A_PER_LO) |=>
      (!run_i && count_i[DATA_W-1:0] == $past(wdata_i)));

  p_oneshot_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && count_i == '0 && !cont_i && !wr_en_i) |=>
      (!run_i && timeout_i && count_i == period_i));

  p_reload_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && count_i == '0 && cont_i && !wr_en_i) |=>
      (run_i && timeout_i && count_i == period_i));

  p_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == A_STATUS && !(run_i && count_i == '0)) |=> !timeout_i);

  p_irq_src_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (timeout_i && irq_en_i));

  p_irq_on_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (timeout_i && irq_en_i) |-> irq_o);

  p_stop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == A_CTRL && wdata_i[CB_STOP]) |=> !run_i);

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !wr_en_i) |=> $stable(count_i));

  p_snap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && (addr_i == A_SNAP_LO || addr_i == A_SNAP_LO + 3'd1)) |=>
      (snap_i == $past(count_i)));

  p_rd_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rdata_o));
endmodule

bind itimer itimer_checker #(.DATA_W(DATA_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .addr_i    (addr_i),
  .wr_en_i   (wr_en_i),
  .rd_en_i   (rd_en_i),
  .wdata_i   (wdata_i),
  .rdata_o   (rdata_o),
  .irq_o     (irq_o),
  .count_i   (count_w),
  .period_i  (period_w),
  .snap_i    (snap_w),
  .run_i     (run_w),
  .timeout_i (to_w),
  .irq_en_i  (irq_en_w),
  .cont_i    (cont_w)
);

// File: tb/itimer_test.sv
module itimer_test;
  localparam int DW = 16;
  localparam int NV = 18;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [2:0]    addr = '0;
  logic          wr_en = 1'b0;
  logic          rd_en = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          irq;

  int n_chk = 0;
  int n_fail = 0;

  itimer #(.DATA_W(DW)) uut (
    .clk_i (clk), .rst_ni (rst_ni), .addr_i (addr), .wr_en_i (wr_en),
    .rd_en_i (rd_en), .wdata_i (wdata), .rdata_o (rdata), .irq_o (irq)
  );

  always #10 clk = ~clk;

  // {is_read, addr, wdata, expected}
  localparam logic [35:0] VEC [NV] = '{
    {1'b1, 3'd0, 16'h0000, 16'h0000},  // R1 status
    {1'b1, 3'd1, 16'h0000, 16'h0000},  // R1 control
    {1'b1, 3'd2, 16'h0000, 16'h0000},  // R1 period lo
    {1'b1, 3'd5, 16'h0000, 16'h0000},  // R1 snapshot hi
    {1'b0, 3'd1, 16'h000F, 16'h0000},  // start+stop together
    {1'b1, 3'd0, 16'h0000, 16'h0000},  // R8 stop wins, not running
    {1'b1, 3'd1, 16'h0000, 16'h0003},  // R3 command bits read zero
    {1'b0, 3'd2, 16'hBEEF, 16'h0000},
    {1'b0, 3'd3, 16'h0012, 16'h0000},
    {1'b1, 3'd2, 16'h0000, 16'hBEEF},  // R2
    {1'b1, 3'd3, 16'h0000, 16'h0012},  // R2
    {1'b1, 3'd6, 16'h0000, 16'h0000},  // R3 undefined
    {1'b1, 3'd7, 16'h0000, 16'h0000},  // R3 undefined
    {1'b0, 3'd1, 16'h0000, 16'h0000},
    {1'b1, 3'd1, 16'h0000, 16'h0000},  // R3
    {1'b0, 3'd4, 16'h5555, 16'h0000},  // data ignored
    {1'b1, 3'd4, 16'h0000, 16'hBEEF},  // R9 / R2 full period loaded
    {1'b1, 3'd5, 16'h0000, 16'h0012}   // R9
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [DW-1:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [DW-1:0] d);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    d = rdata; rd_en = 1'b0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [DW-1:0] v, v2;
    repeat (3) @(negedge clk);
    chk("R1 irq", 32'(irq), 0);
    rst_ni = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][35]) begin
        rd(VEC[i][34:32], v);
        chk($sformatf("R1/R2/R3/R8/R9 vector %0d", i), 32'(v), 32'(VEC[i][15:0]));
      end else begin
        wr(VEC[i][34:32], VEC[i][31:16]);
      end
    end

    // R4 one-shot: expiry period+1 cycles after start
    wr(3'd3, 16'h0000); wr(3'd2, 16'd5);
    wr(3'd1, 16'h0005);
    repeat (5) @(negedge clk);
    chk("R4 before expiry", 32'(irq), 0);
    @(negedge clk);
    chk("R4/R7 expiry irq", 32'(irq), 1);
    rd(3'd0, v);
    chk("R4 status after one-shot", 32'(v), 32'h1);

    // R6 clear by any write
    wr(3'd0, 16'hFFFF);
    chk("R6 irq cleared", 32'(irq), 0);
    rd(3'd0, v);
    chk("R6 status cleared", 32'(v), 0);

    // R7 interrupt disabled
    wr(3'd2, 16'd2);
    wr(3'd1, 16'h0004);
    repeat (4) @(negedge clk);
    rd(3'd0, v);
    chk("R7 flag set", 32'(v), 32'h1);
    chk("R7 irq masked", 32'(irq), 0);
    wr(3'd0, 16'h0000);

    // R5 continuous
    wr(3'd2, 16'd3);
    wr(3'd1, 16'h0007);
    repeat (4) @(negedge clk);
    chk("R5 first tick", 32'(irq), 1);
    wr(3'd0, 16'h0000);
    chk("R5 cleared", 32'(irq), 0);
    repeat (2) @(negedge clk);
    chk("R5 between ticks", 32'(irq), 0);
    @(negedge clk);
    chk("R5 second tick", 32'(irq), 1);
    rd(3'd0, v);
    chk("R5 still running", 32'(v), 32'h3);

    // R8 stop freezes count
    wr(3'd1, 16'h0008);
    wr(3'd4, 16'h0000); rd(3'd4, v);
    repeat (5) @(negedge clk);
    wr(3'd4, 16'h0000); rd(3'd4, v2);
    chk("R8 count frozen", 32'(v2), 32'(v));
    rd(3'd0, v);
    chk("R8 run bit clear", 32'(v[1]), 0);

    // R9 snapshot of live count
    wr(3'd0, 16'h0000);
    wr(3'd3, 16'h0000); wr(3'd2, 16'd100);
    wr(3'd1, 16'h0004);
    repeat (9) @(negedge clk);
    wr(3'd5, 16'hABCD);
    rd(3'd4, v);
    chk("R9 snapshot lo (elapsed 9)", 32'(v), 32'd91);
    rd(3'd5, v);
    chk("R9 snapshot hi", 32'(v), 0);

    // R9 both halves at once
    wr(3'd3, 16'h0001); wr(3'd2, 16'h0002);
    wr(3'd1, 16'h0004);
    wr(3'd4, 16'h0000);
    rd(3'd4, v);
    chk("R9 wide lo", 32'(v), 32'h2);
    rd(3'd5, v);
    chk("R9 wide hi", 32'(v), 32'h1);

    // R2 period write stops a running counter
    rd(3'd0, v);
    chk("R4 running", 32'(v), 32'h2);
    wr(3'd2, 16'd7);
    rd(3'd0, v);
    chk("R2 stopped by period write", 32'(v), 0);
    repeat (4) @(negedge clk);
    wr(3'd4, 16'h0000);
    rd(3'd4, v);
    chk("R2 reloaded lo, held", 32'(v), 32'd7);
    rd(3'd5, v);
    chk("R2 reloaded hi", 32'(v), 32'd1);

    // R10 registered read data
    rd(3'd1, v);
    addr = 3'd2; rd_en = 1'b1;
    chk("R10 not yet updated", 32'(rdata), 32'(v));
    @(negedge clk);
    rd_en = 1'b0;
    chk("R10 updated next cycle", 32'(rdata), 32'd7);
    wr(3'd2, 16'd9);
    @(negedge clk);
    chk("R10 holds without read", 32'(rdata), 32'd7);

    // R6 expiry on the same cycle as a clear wins
    wr(3'd3, 16'h0000); wr(3'd2, 16'd2);
    wr(3'd1, 16'h0005);
    repeat (2) @(negedge clk);
    wr(3'd0, 16'h0000);
    chk("R6 set beats clear", 32'(irq), 1);

    // R1 reset mid-run
    wr(3'd2, 16'd4); wr(3'd1, 16'h0007);
    repeat (3) @(negedge clk);
    rst_ni = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 irq after reset", 32'(irq), 0);
    rd(3'd0, v);
    chk("R1 status after reset", 32'(v), 0);
    rd(3'd2, v);
    chk("R1 period after reset", 32'(v), 0);

    summary();
  end
endmodule